// File: doc/BRIEF.md
# Mode-Strapped Bidirectional Port Controller

This block runs one eight-pin general-purpose I/O port on a register bus. Software sees two registers. The direction register is write-only and selects input or output for each pin. The data register holds the value that output pins drive. When software reads the data register, each pin reports either its latched value or the level sampled at the pad, depending on its direction.

A two-bit strap input, `mode`, selects a single-chip configuration or an expanded-bus configuration. In the expanded configuration the top pin leaves the port and carries an address bit instead. Its direction is pinned to output, and the direction register resets with only that bit set. Each pin can also take its output value from a separate pulse-generator line in place of the data latch, but it still drives only when its direction bit is set.

A standby controller has three states:

- `PWR_RUN`: normal operation.
- `PWR_SOFT_HOLD`: software standby. Register writes are refused, but all contents are kept, so configured outputs go on driving.
- `PWR_HARD_HOLD`: hardware standby. The direction register is reloaded with its reset value on every cycle.

Its transitions are:

- RUN→HARD_HOLD, SOFT_HOLD→HARD_HOLD: when `hw_stby` is 1. This has priority over everything else.
- RUN→SOFT_HOLD: when `sw_stby` is 1 and `hw_stby` is 0.
- SOFT_HOLD→RUN: when `sw_stby` falls.
- HARD_HOLD→RUN: when `hw_stby` falls.

Top module: `gpio_port_ctrl`

## Requirements
- R1: In single-chip modes (`mode` 0 or 1), `pin_oe[i]` equals direction bit i. A 1 means output and a 0 means input. A write to the direction register shows on `pin_oe` right after the clock edge that carries the write strobe.
- R2: A read at the direction address (`DIR_ADDR`, default 2) always returns 0xFF, whatever the register holds.
- R3: The data register (`DATA_ADDR`, default 3) is 0x00 after reset in every mode. A read returns the latched bit for output pins and the synchronised pad level for input pins.
- R4: In expanded modes (`mode` 2 or 3), pin 7 always has `pin_oe[7]`=1 and drives `addr_out_bit`. Writes to direction bit 7 are ignored and the bit stays 1. Bits 6..0 behave as in R1.
- R5: Reset loads the direction register with 0x00 in modes 0 and 1, and with 0x80 in modes 2 and 3.
- R6: `sw_stby`=1 with `hw_stby`=0 enters software standby one edge later. While in software standby, bus writes are ignored, both registers keep their contents, and the output pins keep driving. Dropping `sw_stby` returns to run one edge later.
- R7: `hw_stby`=1 enters hardware standby one edge later, even when `sw_stby` is also 1. From the next edge, and while the state lasts, the direction register holds its R5 reset value and writes are ignored. Dropping `hw_stby` returns to run one edge later.
- R8: For every pin other than an address pin, `pin_out[i]` is `pulse_val[i]` when `pulse_en[i]`=1 and the data latch bit otherwise. `pin_oe[i]` depends only on the direction bit, so pulse output reaches the pad only while direction bit i is 1.
- R9: `pin_in` passes through a two-flop synchroniser. A level change becomes visible in a data read after the second rising edge, and not after the first.
- R10: A write to any address other than the two register addresses changes neither register. Reads of such addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating-mode strap (0,1 single-chip; 2,3 expanded) |
| sw_stby | input | 1 | Software standby request |
| hw_stby | input | 1 | Hardware standby request |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pulse_en | input | 8 | Per-pin select of the pulse-output source |
| pulse_val | input | 8 | Pulse-output values |
| addr_out_bit | input | 1 | Address bit routed to pin 7 in expanded modes |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
The direction register is visible directly on `pin_oe`. A wrong stored bit, a wrong reset value or a lost forced bit therefore shows on that port in the same cycle as the faulty edge, without any read cycle. A wrong standby state shows in two ways. Writes that should be refused take effect at the next edge. Or, in hardware standby, `pin_oe` fails to fall back to the reset value one edge after the state is entered. A wrong synchroniser depth shows as a data read that changes one cycle early or late.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        PWR_RUN       = 2'd0,
        PWR_SOFT_HOLD = 2'd1,
        PWR_HARD_HOLD = 2'd2
    } pwr_state_e;

    // Mode codes 2 and 3 select the expanded-bus configuration.
    function automatic logic mode_is_expanded(input logic [1:0] m);
        return (m == 2'd2) || (m == 2'd3);
    endfunction

endpackage

// File: rtl/gpio_stby_fsm.sv
module gpio_stby_fsm
    import gpio_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_req,
    input  logic hw_req,
    output logic bus_open,
    output logic reinit
);

    pwr_state_e state_q;
    pwr_state_e state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PWR_RUN;
        end else begin
            state_q <= state_n;
        end
    end

    // Hardware standby has priority in every state.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            PWR_RUN: begin
                if (hw_req)      state_n = PWR_HARD_HOLD;
                else if (sw_req) state_n = PWR_SOFT_HOLD;
            end
            PWR_SOFT_HOLD: begin
                if (hw_req)       state_n = PWR_HARD_HOLD;
                else if (!sw_req) state_n = PWR_RUN;
            end
            PWR_HARD_HOLD: begin
                if (!hw_req) state_n = PWR_RUN;
            end
            default: state_n = PWR_RUN;
        endcase
    end

    always_comb begin
        bus_open = 1'b0;
        reinit   = 1'b0;
        unique case (state_q)
            PWR_RUN:       bus_open = 1'b1;
            PWR_SOFT_HOLD: bus_open = 1'b0;
            PWR_HARD_HOLD: reinit   = 1'b1;
            default:       bus_open = 1'b0;
        endcase
    end

    AST_HW_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        hw_req |=> (state_q == PWR_HARD_HOLD)); // R7

    AST_SW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !hw_req && state_q != PWR_HARD_HOLD) |=> (state_q == PWR_SOFT_HOLD)); // R6

endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
    parameter int PINS      = 8,
    parameter int FORCE_BIT = PINS - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            expanded,
    input  logic            reinit,
    input  logic            wr_en,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] dir_q
);

    localparam logic [PINS-1:0] FORCE_MASK = (PINS)'(1) << FORCE_BIT;

    logic [PINS-1:0] rst_val;
    assign rst_val = expanded ? FORCE_MASK : '0;

    for (genvar b = 0; b < PINS; b++) begin : g_bit
        if (b == FORCE_BIT) begin : g_forced
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dir_q[b] <= rst_val[b];
                end else if (reinit) begin
                    dir_q[b] <= rst_val[b];
                end else if (wr_en && !expanded) begin
                    dir_q[b] <= wdata[b];
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dir_q[b] <= 1'b0;
                end else if (reinit) begin
                    dir_q[b] <= 1'b0;
                end else if (wr_en) begin
                    dir_q[b] <= wdata[b];
                end
            end
        end
    end

    AST_FORCED_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        expanded |-> dir_q[FORCE_BIT]); // R4

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !reinit) |=> $stable(dir_q)); // R6

    AST_REINIT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (reinit && $stable(expanded)) |=> (dir_q == rst_val)); // R7

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= din;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int                PINS      = 8,
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] DIR_ADDR  = 4'h2,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              sw_stby,
    input  logic              hw_stby,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    input  logic [PINS-1:0]   pulse_en,
    input  logic [PINS-1:0]   pulse_val,
    input  logic              addr_out_bit,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);

    localparam int ADDR_PIN = PINS - 1;
    localparam int SYNC_STAGES = 2;

    logic            expanded;
    logic            bus_open;
    logic            reinit;
    logic            dir_wr;
    logic            dat_wr;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] dat_q;
    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] port_rd;

    assign expanded = mode_is_expanded(mode);

    gpio_stby_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_req   (sw_stby),
        .hw_req   (hw_stby),
        .bus_open (bus_open),
        .reinit   (reinit)
    );

    assign dir_wr = bus_open && bus_wr && (bus_addr == DIR_ADDR);
    assign dat_wr = bus_open && bus_wr && (bus_addr == DATA_ADDR);

    gpio_dir_reg #(
        .PINS      (PINS),
        .FORCE_BIT (ADDR_PIN)
    ) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .expanded (expanded),
        .reinit   (reinit),
        .wr_en    (dir_wr),
        .wdata    (bus_wdata),
        .dir_q    (dir_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
        end else if (dat_wr) begin
            dat_q <= bus_wdata;
        end
    end

    gpio_pin_sync #(
        .W      (PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_sync)
    );

    assign port_rd = (dat_q & dir_q) | (pin_sync & ~dir_q);

    always_comb begin
        if (bus_addr == DIR_ADDR) begin
            bus_rdata = '1;
        end else if (bus_addr == DATA_ADDR) begin
            bus_rdata = port_rd;
        end else begin
            bus_rdata = '0;
        end
    end

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        if (p == ADDR_PIN) begin : g_addr_pin
            assign pin_out[p] = expanded ? addr_out_bit
                              : (pulse_en[p] ? pulse_val[p] : dat_q[p]);
        end else begin : g_port_pin
            assign pin_out[p] = pulse_en[p] ? pulse_val[p] : dat_q[p];
        end
    end

    assign pin_oe = dir_q;

    AST_DIR_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DIR_ADDR) |-> (bus_rdata == {PINS{1'b1}})); // R2

    AST_ADDR_PIN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        expanded |-> (pin_oe[ADDR_PIN] && pin_out[ADDR_PIN] == addr_out_bit)); // R4

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != DIR_ADDR && bus_addr != DATA_ADDR) |-> (bus_rdata == '0)); // R10

    AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_open && bus_wr) |=> $stable(dat_q)); // R6

endmodule

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       sw_stby = 1'b0;
    logic       hw_stby = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pulse_en = 8'h00;
    logic [7:0] pulse_val = 8'h00;
    logic       addr_out_bit = 1'b0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [3:0] A_DIR = 4'h2;
    localparam logic [3:0] A_DAT = 4'h3;

    always #2 clk = ~clk;

    gpio_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .sw_stby(sw_stby), .hw_stby(hw_stby),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pulse_en(pulse_en), .pulse_val(pulse_val),
        .addr_out_bit(addr_out_bit), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; mode = m; sw_stby = 1'b0; hw_stby = 1'b0;
        pin_in = 8'h00; pulse_en = 8'h00; bus_wr = 1'b0;
        ticks(2);
        rst_n = 1'b1;
        ticks(1);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                failures++;
                checks++;
                $display("FAIL watchdog got=hung expected=finish");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] r;

        // R5 / R3 / R2: reset state in every mode code
        for (int m = 0; m < 4; m++) begin
            do_reset(m[1:0]);
            chk("R5 reset direction", pin_oe, (m >= 2) ? 8'h80 : 8'h00);
            rd(A_DIR, r); chk("R2 direction read", r, 8'hFF);
            rd(A_DAT, r); chk("R3 data reset", r, 8'h00);
        end

        // R1: every direction value, single-chip
        do_reset(2'd0);
        for (int w = 0; w < 256; w++) begin
            wr(A_DIR, w[7:0]);
            chk("R1 direction to oe", pin_oe, w[7:0]);
            rd(A_DIR, r); chk("R2 direction read", r, 8'hFF);
        end

        // R4: every direction value, expanded
        do_reset(2'd3);
        for (int w = 0; w < 256; w++) begin
            wr(A_DIR, w[7:0]);
            chk("R4 forced bit7", pin_oe, w[7:0] | 8'h80);
            addr_out_bit = w[0];
            #1;
            chk("R4 address pin", {7'd0, pin_out[7]}, {7'd0, w[0]});
        end

        // R3: mixed-direction readback
        do_reset(2'd1);
        wr(A_DIR, 8'hF0);
        for (int p = 0; p < 256; p++) begin
            wr(A_DAT, p[7:0] ^ 8'h5A);
            pin_in = p[7:0];
            ticks(2);
            rd(A_DAT, r);
            chk("R3 data readback", r, ((p[7:0] ^ 8'h5A) & 8'hF0) | (p[7:0] & 8'h0F));
        end

        // R9: two-edge synchroniser latency
        do_reset(2'd0);
        pin_in = 8'hC3;
        ticks(1);
        rd(A_DAT, r); chk("R9 not after one edge", r, 8'h00);
        ticks(1);
        rd(A_DAT, r); chk("R9 after two edges", r, 8'hC3);

        // R8: pulse path selection
        do_reset(2'd1);
        wr(A_DIR, 8'hFF);
        wr(A_DAT, 8'h3C);
        for (int e = 0; e < 256; e++) begin
            pulse_en = e[7:0];
            pulse_val = ~e[7:0] ^ 8'h96;
            #1;
            chk("R8 pulse mux", pin_out, (pulse_en & pulse_val) | (~pulse_en & 8'h3C));
        end
        wr(A_DIR, 8'h0F);
        pulse_en = 8'hFF;
        #1;
        chk("R8 oe gated by direction", pin_oe, 8'h0F);
        do_reset(2'd2);
        pulse_en = 8'hFF; pulse_val = 8'h00; addr_out_bit = 1'b1;
        #1;
        chk("R8 R4 address pin beats pulse", {7'd0, pin_out[7]}, 8'h01);

        // R10: unmapped address
        do_reset(2'd0);
        wr(A_DIR, 8'h55);
        wr(A_DAT, 8'h99);
        wr(4'h0, 8'hFF);
        wr(4'hF, 8'h00);
        chk("R10 direction untouched", pin_oe, 8'h55);
        rd(A_DAT, r); chk("R10 data untouched", r & 8'h55, 8'h99 & 8'h55);
        rd(4'h0, r); chk("R10 unmapped read", r, 8'h00);

        // R6: software standby keeps state and drive
        do_reset(2'd0);
        wr(A_DIR, 8'h33);
        wr(A_DAT, 8'hAA);
        sw_stby = 1'b1;
        ticks(1);
        wr(A_DIR, 8'hCC);
        wr(A_DAT, 8'h55);
        chk("R6 direction held", pin_oe, 8'h33);
        chk("R6 pins keep driving", pin_out, 8'hAA);
        sw_stby = 1'b0;
        ticks(1);
        rd(A_DAT, r); chk("R6 data held", r & 8'h33, 8'hAA & 8'h33);
        wr(A_DIR, 8'h0C);
        chk("R6 writes resume", pin_oe, 8'h0C);

        // R7: hardware standby reloads, priority over software
        do_reset(2'd2);
        wr(A_DIR, 8'h7F);
        chk("R7 pre-standby", pin_oe, 8'hFF);
        hw_stby = 1'b1; sw_stby = 1'b1;
        ticks(2);
        chk("R7 expanded reload", pin_oe, 8'h80);
        wr(A_DIR, 8'h0F);
        chk("R7 writes ignored", pin_oe, 8'h80);
        hw_stby = 1'b0; sw_stby = 1'b0;
        ticks(1);
        wr(A_DIR, 8'h01);
        chk("R7 back to run", pin_oe, 8'h81);
        do_reset(2'd0);
        wr(A_DIR, 8'hFF);
        hw_stby = 1'b1;
        ticks(2);
        chk("R7 single-chip reload", pin_oe, 8'h00);
        hw_stby = 1'b0;
        ticks(1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule